// File: doc/BRIEF.md
# Static Memory Access Timing Sequencer

This block turns one request from the internal bus into a complete access cycle on an external asynchronous SRAM. It drives the 26-bit address, the 16-bit data bus with its output enable, an active-low chip enable and active-low read and write strobes. Each access runs through three phases: a chip-enable setup phase with both strobes high, a strobe phase, and a chip-enable hold phase after the strobe returns high. The length of each phase is programmable.

Requests arrive on a valid/ready port. `req_ready` is high only while the sequencer is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. The setup, wait and hold codes on the `cfg_*` pins are latched at that same edge. While an access is in progress the requester is held off. Completion is signalled by a single-cycle `rsp_valid` pulse. That pulse has no back-pressure: on a read, `rsp_rdata` is valid during the pulse and keeps its value until the next read completes. The external wait pin, `mem_wait_n`, is active low. It passes through a two-flop synchronizer and can stretch the strobe beyond its programmed width.

Top module: `sram_timing_seq`

## Requirements
- R1: After reset, and whenever no access is in progress: `mem_ce_n`, `mem_rd_n` and `mem_wr_n` are 1, `mem_dq_oe` is 0 and `req_ready` is 1.
- R2: Setup phase length is `cfg_setup`+1 cycles (codes 0..3 give 1..4 cycles). During this phase `mem_ce_n` is 0 and both strobes are 1. The phase begins in the cycle after the accepting edge.
- R3: With `mem_wait_n` held high, the strobe stays low for `cfg_wait`+1 cycles (codes 0..15 give 1..16 cycles).
- R4: Hold phase length is `cfg_hold`+1 cycles (codes 0..3 give 1..4 cycles). It is counted from the strobe's return to 1 up to the return of `mem_ce_n` to 1.
- R5: The strobe phase ends only after the static count has expired and the synchronized wait input reads 1. Suppose `mem_wait_n` is low when the strobe begins and rises during strobe cycle K. The strobe then lasts max(`cfg_wait`+1, K+2) cycles. So a low level that ends early in the static count adds nothing.
- R6: On a read (`req_write`=0), `mem_rd_n` is the strobe. `mem_dq_in` is captured at the clock edge where the strobe ends, and it is presented on `rsp_rdata` while `rsp_valid` is 1.
- R7: On a write (`req_write`=1), `mem_wr_n` is the strobe and `mem_rd_n` stays 1. `mem_dq_oe` is 1 and `mem_dq_out` equals the request data in every cycle from the first setup cycle to the last hold cycle.
- R8: `rsp_valid` is 1 for exactly one cycle, the last hold cycle. `req_ready` is 0 whenever `mem_ce_n` is 0. Between two accesses `mem_ce_n` returns to 1 for at least one cycle.
- R9: Changes on `cfg_setup`, `cfg_wait` or `cfg_hold` after the accepting edge do not affect the access in progress.
- R10: `mem_addr` equals the request address and stays unchanged in every cycle where `mem_ce_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_setup | input | 2 | Setup code, cycles = code+1 |
| cfg_wait | input | 4 | Static wait code, strobe cycles = code+1 |
| cfg_hold | input | 2 | Hold code, cycles = code+1 |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 26 | Request address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Captured read data |
| mem_addr | output | 26 | External address bus |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_dq_out | output | 16 | Data bus output value |
| mem_dq_oe | output | 1 | Data bus output enable |
| mem_dq_in | input | 16 | Data bus input value |
| mem_wait_n | input | 1 | External wait, active low, asynchronous |

## Verification
The phases follow one another with no gaps. The first setup cycle comes one cycle after the accepting edge. The strobe follows `cfg_setup`+1 cycles later, and `rsp_valid` falls in the last of the `cfg_hold`+1 hold cycles. A release of the wait pin in strobe cycle K shows up two edges later, because of the synchronizer. The checks measure each phase on falling edges by counting monitor samples. They do not predict absolute times. The expected phase lengths and the read data are pushed into a queue when the request is issued, and the monitor compares its counts against that queue on the `rsp_valid` sample. The sample right after `rsp_valid` is checked for an idle chip enable.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/sram_wait_sync.sv
module sram_wait_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_n,
  output logic sync_n
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= async_n;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], async_n};
      end
    end
  endgenerate

  assign sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sram_phase_ctl.sv
module sram_phase_ctl
  import sram_seq_pkg::*;
#(
  parameter int SETUP_W = 2,
  parameter int WAIT_W  = 4,
  parameter int HOLD_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SETUP_W-1:0] setup_code,
  input  logic [WAIT_W-1:0]  wait_code,
  input  logic [HOLD_W-1:0]  hold_code,
  input  logic              ext_ok,
  output phase_e            phase,
  output logic              strobe_end,
  output logic              done
);
  localparam int CNT_W = max3(SETUP_W, WAIT_W, HOLD_W);

  phase_e             phase_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [WAIT_W-1:0]  wait_q;
  logic [HOLD_W-1:0]  hold_q;
  logic               cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      wait_q  <= '1;
      hold_q  <= '1;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (start) begin
            phase_q <= PH_SETUP;
            cnt_q   <= CNT_W'(setup_code);
            wait_q  <= wait_code;
            hold_q  <= hold_code;
          end
        end
        PH_SETUP: begin
          if (cnt_zero) begin
            phase_q <= PH_STROBE;
            cnt_q   <= CNT_W'(wait_q);
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        PH_STROBE: begin
          if (!cnt_zero) begin
            cnt_q <= cnt_q - CNT_W'(1);
          end else if (ext_ok) begin
            phase_q <= PH_HOLD;
            cnt_q   <= CNT_W'(hold_q);
          end
        end
        PH_HOLD: begin
          if (cnt_zero) phase_q <= PH_IDLE;
          else          cnt_q   <= cnt_q - CNT_W'(1);
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase      = phase_q;
  assign strobe_end = (phase_q == PH_STROBE) && cnt_zero && ext_ok;
  assign done       = (phase_q == PH_HOLD) && cnt_zero;

  // R5: wait pin cannot end the strobe while static cycles remain
  a_r5_static_first: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_STROBE && !cnt_zero) |=> (phase_q == PH_STROBE));

  // R4: hold completion returns to idle
  a_r4_hold_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (phase_q == PH_IDLE));

  // R2: an accepted request enters setup
  a_r2_start_setup: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE && start) |=> (phase_q == PH_SETUP));

  // R5: the strobe ends only through an expired count with wait released
  a_r5_exit_rule: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_STROBE && !ext_ok) |=> (phase_q == PH_STROBE));
endmodule

// File: rtl/sram_timing_seq.sv
module sram_timing_seq
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W      = 26,
  parameter int DATA_W      = 16,
  parameter int SETUP_W     = 2,
  parameter int WAIT_W      = 4,
  parameter int HOLD_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SETUP_W-1:0] cfg_setup,
  input  logic [WAIT_W-1:0]  cfg_wait,
  input  logic [HOLD_W-1:0]  cfg_hold,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic               mem_ce_n,
  output logic               mem_rd_n,
  output logic               mem_wr_n,
  output logic [DATA_W-1:0]  mem_dq_out,
  output logic               mem_dq_oe,
  input  logic [DATA_W-1:0]  mem_dq_in,
  input  logic               mem_wait_n
);
  phase_e            phase;
  logic              strobe_end;
  logic              done;
  logic              wait_ok;
  logic              accept;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              write_q;

  assign req_ready = (phase == PH_IDLE);
  assign accept    = req_valid && req_ready;

  sram_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_n (mem_wait_n),
    .sync_n  (wait_ok)
  );

  sram_phase_ctl #(
    .SETUP_W (SETUP_W),
    .WAIT_W  (WAIT_W),
    .HOLD_W  (HOLD_W)
  ) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .setup_code (cfg_setup),
    .wait_code  (cfg_wait),
    .hold_code  (cfg_hold),
    .ext_ok     (wait_ok),
    .phase      (phase),
    .strobe_end (strobe_end),
    .done       (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      write_q <= req_write;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    rdata_q <= '0;
    else if (strobe_end && !write_q) rdata_q <= mem_dq_in;
  end

  assign mem_addr   = addr_q;
  assign mem_ce_n   = (phase == PH_IDLE);
  assign mem_rd_n   = !((phase == PH_STROBE) && !write_q);
  assign mem_wr_n   = !((phase == PH_STROBE) && write_q);
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = (phase != PH_IDLE) && write_q;
  assign rsp_valid  = done;
  assign rsp_rdata  = rdata_q;

  // R7: never both strobes at once
  a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_rd_n && !mem_wr_n));

  // R2: a strobe only inside an active chip enable
  a_r2_strobe_in_ce: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rd_n || !mem_wr_n) |-> !mem_ce_n);

  // R8: completion is a single-cycle pulse
  a_r8_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R8: no request taken during an access
  a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> !req_ready);

  // R10: address held while chip enable is low
  a_r10_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  // R8: chip enable returns high after completion
  a_r8_ce_gap: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> mem_ce_n);
endmodule

// File: tb/sram_timing_seq_test.sv
module sram_timing_seq_test;
  localparam time CLK_PERIOD = 10ns;

  typedef struct {
    bit          write;
    logic [25:0] addr;
    logic [15:0] wdata;
    int          su;
    int          st;
    int          ho;
    int          rel_k;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_setup = 2'd0;
  logic [3:0]  cfg_wait = 4'd0;
  logic [1:0]  cfg_hold = 2'd0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [25:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [25:0] mem_addr;
  logic        mem_ce_n, mem_rd_n, mem_wr_n, mem_dq_oe;
  logic [15:0] mem_dq_out;
  logic [15:0] mem_dq_in;
  logic        mem_wait_n = 1'b1;

  int checks = 0;
  int failures = 0;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  // memory model: data valid only while the read strobe is low
  assign mem_dq_in = mem_rd_n ? 16'hDEAD : (mem_addr[15:0] ^ 16'h5AC3);

  sram_timing_seq uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_setup(cfg_setup), .cfg_wait(cfg_wait), .cfg_hold(cfg_hold),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_rd_n(mem_rd_n),
    .mem_wr_n(mem_wr_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in), .mem_wait_n(mem_wait_n)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // driver: pushes the expectation, issues the request, scrambles config (R9)
  task automatic do_access(input bit wr, input logic [25:0] a, input logic [15:0] d,
                           input int s, input int w, input int h, input int rel_k);
    exp_t e;
    int st;
    st = w + 1;
    if (rel_k != 0 && rel_k + 2 > st) st = rel_k + 2;
    e.write = wr; e.addr = a; e.wdata = d;
    e.su = s + 1; e.st = st; e.ho = h + 1; e.rel_k = rel_k;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    exp_q.push_back(e);
    cfg_setup = 2'(s); cfg_wait = 4'(w); cfg_hold = 2'(h);
    req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
    if (rel_k != 0) mem_wait_n = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    cfg_setup = ~cfg_setup; cfg_wait = ~cfg_wait; cfg_hold = ~cfg_hold;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // monitor: measures phase lengths and pops expectations on rsp_valid
  initial begin
    int su = 0, st = 0, ho = 0;
    bit addr_bad = 0, bus_bad = 0, dir_bad = 0, busy_bad = 0, idle_next = 0;
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (idle_next) begin
          idle_next = 0;
          chk(mem_ce_n == 1'b1 && req_ready == 1'b1, "R8 ce gap after completion",
              {mem_ce_n, req_ready}, 2'b11);
        end
        if (!mem_ce_n) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R1 access without request", mem_ce_n, 1);
          end else begin
            e = exp_q[0];
            if (mem_addr != e.addr) addr_bad = 1;
            if (req_ready) busy_bad = 1;
            if (mem_dq_oe != e.write) bus_bad = 1;
            if (e.write && mem_dq_out != e.wdata) bus_bad = 1;
            if (!mem_rd_n || !mem_wr_n) begin
              st++;
              if (e.write ? !mem_rd_n : !mem_wr_n) dir_bad = 1;
              if (e.rel_k != 0 && st == e.rel_k) mem_wait_n = 1'b1;
            end else if (st == 0) su++;
            else ho++;
          end
        end
        if (rsp_valid && exp_q.size() != 0) begin
          e = exp_q.pop_front();
          chk(su == e.su, "R2 setup length", su, e.su);
          if (e.rel_k != 0) chk(st == e.st, "R5 stretched strobe length", st, e.st);
          else              chk(st == e.st, "R3 strobe length", st, e.st);
          chk(ho == e.ho, "R4 hold length", ho, e.ho);
          chk(!addr_bad, "R10 address stable and correct", addr_bad, 0);
          chk(!busy_bad, "R8 ready low while busy", busy_bad, 0);
          chk(!dir_bad, "R7 strobe direction", dir_bad, 0);
          if (e.write) chk(!bus_bad, "R7 data bus driven through access", bus_bad, 0);
          else begin
            chk(!bus_bad, "R6 data bus not driven on read", bus_bad, 0);
            chk(rsp_rdata == (e.addr[15:0] ^ 16'h5AC3), "R6 read data",
                rsp_rdata, e.addr[15:0] ^ 16'h5AC3);
          end
          su = 0; st = 0; ho = 0;
          addr_bad = 0; bus_bad = 0; dir_bad = 0; busy_bad = 0;
          idle_next = 1;
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(mem_ce_n && mem_rd_n && mem_wr_n, "R1 strobes idle in reset",
        {mem_ce_n, mem_rd_n, mem_wr_n}, 3'b111);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_ce_n && mem_rd_n && mem_wr_n, "R1 strobes idle after reset",
        {mem_ce_n, mem_rd_n, mem_wr_n}, 3'b111);
    chk(!mem_dq_oe, "R1 bus released", mem_dq_oe, 0);
    chk(req_ready, "R1 ready when idle", req_ready, 1);
    chk(!rsp_valid, "R1 no response when idle", rsp_valid, 0);

    // minimal timing read (R2 R3 R4 R6)
    do_access(1'b0, 26'h0001234, 16'h0, 0, 0, 0, 0);
    drain();
    // maximal timing write (R7 R9)
    do_access(1'b1, 26'h3FFFFFF, 16'hBEEF, 3, 15, 3, 0);
    drain();
    // mid values read
    do_access(1'b0, 26'h2A5A5A5, 16'h0, 1, 2, 2, 0);
    drain();
    // R5: wait released late stretches write strobe
    do_access(1'b1, 26'h0100040, 16'h1357, 2, 5, 1, 8);
    drain();
    // R5: wait released early within static count adds nothing
    do_access(1'b0, 26'h00ABCDE, 16'h0, 0, 6, 0, 1);
    drain();
    // R5: zero static wait with external wait
    do_access(1'b0, 26'h1000F0F, 16'h0, 1, 0, 3, 3);
    drain();
    // back-to-back: R8 ce gap and ready rules
    do_access(1'b1, 26'h0000010, 16'hA001, 0, 1, 0, 0);
    do_access(1'b1, 26'h0000011, 16'hA002, 1, 0, 1, 0);
    do_access(1'b0, 26'h0000012, 16'h0, 0, 3, 2, 0);
    drain();
    repeat (3) @(negedge clk);
    chk(mem_ce_n && req_ready && !mem_dq_oe, "R1 idle after traffic",
        {mem_ce_n, req_ready, mem_dq_oe}, 3'b110);
    summary();
    $finish;
  end
endmodule